// File: doc/BRIEF.md
# Gated Johnson decade counter

The block divides a slow count signal by ten. Its core is a five-stage twisted-ring (Johnson) register that walks through ten codes. Each code differs from the one before it in a single bit. Two asynchronous inputs, a count clock and an active-high inhibit, are brought into the system clock domain through synchronizers and then edge-detected. The counter takes one step on either of two events:

- a rising edge of the count clock while inhibit is low;
- a falling edge of inhibit while the count clock is high.

The second event lets inhibit serve as a falling-edge clock when the count clock is tied high.

A carry output is high for the first half of the decade and low for the second half. It rises exactly when the count wraps from nine to zero, so it can feed the count clock input of the next decade in a chain. Any ring pattern outside the ten legal codes is sent to the zero code at the next counting event, so the ring cannot lock up in a parasitic loop. An active-high asynchronous reset loads the reset code at once and overrides counting.

The reset code is the parameter `RESET_STATE`, which defaults to all zeros. Overriding it to an illegal pattern is how the recovery path is exercised.

Top module: `decade_ring_counter`

## Requirements
- R1: While `rst_i` is high, `state_o` equals `RESET_STATE` (default 5'b00000), including immediately after `rst_i` rises between system clock edges. Count-clock and inhibit activity during reset has no effect.
- R2: A rising edge on `count_clk_i` while `inhibit_i` is low advances the counter by one step. The change shows on `state_o` within SYNC_STAGES+1 system clock edges.
- R3: While `inhibit_i` is high, rising edges on `count_clk_i` leave `state_o` unchanged.
- R4: While `count_clk_i` is high, a falling edge on `inhibit_i` advances the counter by one step.
- R5: These transitions leave `state_o` unchanged: a falling edge of `count_clk_i`, a rising edge of `inhibit_i`, and a falling edge of `inhibit_i` while `count_clk_i` is low.
- R6: From zero, successive steps give 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 (written state_o[4] down to state_o[0]), then 00000 again.
- R7: `carry_o` is high for the first five codes of R6 and low for the last five. It rises only on the step from 10000 to 00000, which gives one rising edge per ten steps.
- R8: When `state_o` holds a code that is not in the R6 list, the next counting event sets it to 00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples all inputs |
| rst_i | input | 1 | Asynchronous reset, active high |
| count_clk_i | input | 1 | Count clock; rising edge counts when inhibit is low |
| inhibit_i | input | 1 | Count inhibit; falling edge counts when count clock is high |
| state_o | output | STAGES (5) | Johnson ring code |
| carry_o | output | 1 | Decade carry, high during codes 0 to 4 |

## Verification
A corrupted ring shows on `state_o` as a code with more than one 0/1 boundary. From such a code the block must return to 00000 on the very next counting event. That event appears at the port SYNC_STAGES+1 system clocks after the input edge that causes it. A step lost or doubled in the edge logic shows as a wrong code on the next check. It also moves the carry rise away from the tenth step, which a cascaded decade would see as a miscount within one decade.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int unsigned DEF_STAGES      = 5;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Origin of a counting event, used for readability in the edge unit
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_CLOCK   = 2'd1,
        SRC_INHIBIT = 2'd2
    } step_src_e;

    // Synchronized levels of the two count inputs
    typedef struct packed {
        logic clk_lvl;
        logic inh_lvl;
    } pin_pair_t;

endpackage

// File: rtl/decade_edge_unit.sv
module decade_edge_unit
    import decade_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic count_clk_i,
    input  logic inhibit_i,
    output logic step_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] clk_sync;
        logic [SYNC_STAGES-1:0] inh_sync;
        pin_pair_t              prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;
    pin_pair_t  now_lvl;
    logic       clk_rise, inh_fall;
    step_src_e  src;

    always_comb begin
        r_d = r_q;
        r_d.clk_sync[0] = count_clk_i;
        r_d.inh_sync[0] = inhibit_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            r_d.clk_sync[k] = r_q.clk_sync[k-1];
            r_d.inh_sync[k] = r_q.inh_sync[k-1];
        end
        now_lvl.clk_lvl = r_q.clk_sync[SYNC_STAGES-1];
        now_lvl.inh_lvl = r_q.inh_sync[SYNC_STAGES-1];
        r_d.prev        = now_lvl;

        clk_rise = now_lvl.clk_lvl & ~r_q.prev.clk_lvl;
        inh_fall = ~now_lvl.inh_lvl & r_q.prev.inh_lvl;

        if (clk_rise && !now_lvl.inh_lvl) begin
            src = SRC_CLOCK;
        end else if (inh_fall && now_lvl.clk_lvl) begin
            src = SRC_INHIBIT;
        end else begin
            src = SRC_NONE;
        end
        step_o = (src != SRC_NONE);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/decade_ring_next.sv
module decade_ring_next #(
    parameter int unsigned STAGES = 5
) (
    input  logic [STAGES-1:0] cur_i,
    input  logic              step_i,
    output logic [STAGES-1:0] nxt_o,
    output logic              legal_o
);

    localparam int unsigned EDGES = STAGES - 1;

    logic [EDGES-1:0] boundary;

    genvar g;
    generate
        for (g = 0; g < EDGES; g++) begin : g_bound
            assign boundary[g] = cur_i[g+1] ^ cur_i[g];
        end
    endgenerate

    always_comb begin
        legal_o = ($countones(boundary) <= 1);
        nxt_o   = cur_i;
        if (step_i) begin
            if (legal_o) begin
                nxt_o = {cur_i[STAGES-2:0], ~cur_i[STAGES-1]};
            end else begin
                nxt_o = '0;
            end
        end
    end

endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter
    import decade_pkg::*;
#(
    parameter int unsigned       STAGES      = DEF_STAGES,
    parameter int unsigned       SYNC_STAGES = DEF_SYNC_STAGES,
    parameter logic [STAGES-1:0] RESET_STATE = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              count_clk_i,
    input  logic              inhibit_i,
    output logic [STAGES-1:0] state_o,
    output logic              carry_o
);

    typedef struct packed {
        logic [STAGES-1:0] ring;
    } ring_regs_t;

    ring_regs_t        s_d, s_q;
    logic              step;
    logic              legal;
    logic [STAGES-1:0] ring_nxt;

    decade_edge_unit #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .count_clk_i(count_clk_i),
        .inhibit_i  (inhibit_i),
        .step_o     (step)
    );

    decade_ring_next #(
        .STAGES(STAGES)
    ) u_next (
        .cur_i  (s_q.ring),
        .step_i (step),
        .nxt_o  (ring_nxt),
        .legal_o(legal)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ring = ring_nxt;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            s_q.ring <= RESET_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q.ring;
    assign carry_o = ~s_q.ring[STAGES-1];

endmodule

// File: rtl/decade_ring_chk.sv
module decade_ring_chk #(
    parameter int unsigned       STAGES      = 5,
    parameter logic [STAGES-1:0] RESET_STATE = '0
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              step_i,
    input logic [STAGES-1:0] state_i,
    input logic              carry_i
);

    logic legal_now;
    assign legal_now = ($countones(state_i[STAGES-1:1] ^ state_i[STAGES-2:0]) <= 1);

    // R1
    reset_value_chk: assert property (@(posedge clk_i)
        rst_i |-> state_i == RESET_STATE);

    // R3
    hold_without_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(state_i));

    // R6
    legal_advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && legal_now) |=>
            state_i == {$past(state_i[STAGES-2:0]), ~$past(state_i[STAGES-1])});

    // R8
    illegal_recover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !legal_now) |=> state_i == '0);

    // R7
    carry_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(carry_i) |-> ($past(step_i) && $past(state_i[STAGES-1])));

endmodule

bind decade_ring_counter decade_ring_chk #(
    .STAGES     (STAGES),
    .RESET_STATE(RESET_STATE)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (step),
    .state_i(state_o),
    .carry_i(carry_o)
);

// File: tb/test_decade_ring_counter.sv
module test_decade_ring_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       cclk = 1'b0;
    logic       inh = 1'b0;
    logic [4:0] state;
    logic       carry;
    logic       b_cclk = 1'b0;
    logic [4:0] b_state;
    logic       b_carry;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    decade_ring_counter i_decade_ring_counter (
        .clk_i(clk), .rst_i(rst), .count_clk_i(cclk), .inhibit_i(inh),
        .state_o(state), .carry_o(carry)
    );

    decade_ring_counter #(.RESET_STATE(5'b01010)) i_bad_start (
        .clk_i(clk), .rst_i(rst), .count_clk_i(b_cclk), .inhibit_i(1'b0),
        .state_o(b_state), .carry_o(b_carry)
    );

    // {count_clk, inhibit, expected state[4:0], expected carry}
    localparam logic [7:0] VECS [26] = '{
        {2'b10, 5'b00001, 1'b1}, {2'b00, 5'b00001, 1'b1},   // R2
        {2'b10, 5'b00011, 1'b1}, {2'b00, 5'b00011, 1'b1},
        {2'b01, 5'b00011, 1'b1}, {2'b11, 5'b00011, 1'b1},   // R3
        {2'b01, 5'b00011, 1'b1}, {2'b11, 5'b00011, 1'b1},
        {2'b10, 5'b00111, 1'b1}, {2'b11, 5'b00111, 1'b1},   // R4, R5
        {2'b10, 5'b01111, 1'b1}, {2'b00, 5'b01111, 1'b1},
        {2'b10, 5'b11111, 1'b0}, {2'b00, 5'b11111, 1'b0},   // R6, R7
        {2'b10, 5'b11110, 1'b0}, {2'b00, 5'b11110, 1'b0},
        {2'b10, 5'b11100, 1'b0}, {2'b00, 5'b11100, 1'b0},
        {2'b10, 5'b11000, 1'b0}, {2'b00, 5'b11000, 1'b0},
        {2'b10, 5'b10000, 1'b0}, {2'b00, 5'b10000, 1'b0},
        {2'b10, 5'b00000, 1'b1}, {2'b00, 5'b00000, 1'b1},
        {2'b01, 5'b00000, 1'b1}, {2'b00, 5'b00000, 1'b1}    // R5
    };

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: state/carry actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic i);
        @(negedge clk);
        cclk = c;
        inh  = i;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse();
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    initial begin
        int rises;
        logic last_carry;
        #1 rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {state, carry}, {5'b00000, 1'b1});
        check("R1", b_state, 6'(5'b01010));
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int n = 0; n < 26; n++) begin
            drive(VECS[n][7], VECS[n][6]);
            check("R2-R7 vector", {state, carry}, VECS[n][5:0]);
        end

        // R7: two carry rises across twenty steps
        rises = 0;
        last_carry = carry;
        for (int n = 0; n < 20; n++) begin
            pulse();
            if (carry && !last_carry) rises++;
            last_carry = carry;
        end
        check("R7 rises", 6'(rises), 6'd2);
        check("R6 after 20", {state, carry}, {5'b00000, 1'b1});

        // R1: asynchronous reset in mid count, priority over edges
        repeat (3) pulse();
        check("R2 mid", {state, carry}, {5'b00111, 1'b1});
        @(negedge clk);
        #2 rst = 1'b1;
        #1 check("R1 async", {state, carry}, {5'b00000, 1'b1});
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        check("R1 priority", {state, carry}, {5'b00000, 1'b1});
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        pulse();
        check("R2 after reset", {state, carry}, {5'b00001, 1'b1});

        // R8: illegal start code recovers to zero, then counts normally
        check("R8 untouched", b_state, 6'(5'b01010));
        @(negedge clk); b_cclk = 1'b1; repeat (5) @(negedge clk);
        check("R8 recover", {b_state, b_carry}, {5'b00000, 1'b1});
        @(negedge clk); b_cclk = 1'b0; repeat (5) @(negedge clk);
        @(negedge clk); b_cclk = 1'b1; repeat (5) @(negedge clk);
        check("R8 resume", {b_state, b_carry}, {5'b00001, 1'b1});

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule